// File: doc/BRIEF.md
# Retimed Two-Operand ALU with Local Feedback

This block is one arithmetic functional unit inside a cluster that runs a modulo schedule. Two 32-bit operands arrive from the cluster crossbar. Each operand passes through its own input register. A per-phase configuration word decides whether that register loads in a given cycle. An operand can therefore wait inside the unit for several cycles, and operands that arrive in different cycles can be captured one at a time and combined later.

The unit keeps a private feedback register that can hold its own result. Either input register can load from the feedback register instead of from the crossbar, so a chain of operations on the same unit does not need to leave the unit. The caller supplies the current schedule phase every cycle. The unit looks up one configuration word per phase from a small store. The caller fills that store through a simple write port before the schedule starts. The output is a registered result.

Top module: `fu_retime_alu`

## Requirements
- R1: The opcode field selects the ALU function: 000 add, 001 subtract (A minus B), 010 bitwise and, 011 bitwise or, 100 bitwise xor, 101 pass A. Add and subtract wrap modulo 2^32.
- R2: The opcodes 110 and 111 produce a zero result.
- R3: The configuration word is 8 bits wide. Bit 7 is the A load enable and bit 6 is the B load enable. Bit 5 selects the A source and bit 4 selects the B source, with 1 meaning the feedback register. Bit 3 is the feedback capture enable and bits 2:0 are the opcode. A write with `cfg_we` high stores `cfg_data` into the entry at `cfg_addr` at the clock edge. Other entries are not changed. The entry selected by `phase` takes effect in the same cycle.
- R4: An input register loads at a clock edge only when its enable bit is set in the current phase's word. Otherwise it keeps its value.
- R5: Operands captured in different cycles under different phases are combined in a later cycle, in whatever order they were captured.
- R6: In every cycle, the result register takes the current phase's operation applied to the input registers' contents at the start of that cycle. A result is therefore visible two edges after its operands were presented.
- R7: The feedback register captures the ALU output at an edge when the current phase's feedback enable is set. Otherwise it holds its value.
- R8: When a source select bit is 1 and the matching enable is set, that input register loads the feedback register's value instead of the crossbar input.
- R9: A synchronous active-high reset clears both input registers, the feedback register, the result register and every configuration entry.
- R10: With the default of 16 phases, every phase index from 0 to 15 addresses its own configuration entry.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 4 | Phase entry to write |
| cfg_data | input | 8 | Configuration word to store |
| phase | input | 4 | Current modulo-schedule phase |
| opnd_a | input | 32 | Crossbar operand A |
| opnd_b | input | 32 | Crossbar operand B |
| result | output | 32 | Registered ALU result |

## Verification
The bench builds the unit with its defaults: a 32-bit datapath and 16 phases. The 32-bit width brings carry-out wrap and sign-crossing subtraction within reach. The 16 phases let the highest phase index 15 and the isolation between distinct phase entries be exercised. Phases 1 to 8 are used for separate hold, reorder and feedback schedules, so each behaviour sits in its own configuration entry and no test depends on another entry's contents.

// File: rtl/fu_pkg.sv
package fu_pkg;

  typedef enum logic [2:0] {
    OP_ADD  = 3'b000,
    OP_SUB  = 3'b001,
    OP_AND  = 3'b010,
    OP_OR   = 3'b011,
    OP_XOR  = 3'b100,
    OP_PASS = 3'b101,
    OP_RSV6 = 3'b110,
    OP_RSV7 = 3'b111
  } fu_op_e;

  typedef struct packed {
    logic   en_a;
    logic   en_b;
    logic   sel_a;
    logic   sel_b;
    logic   fb_en;
    fu_op_e op;
  } fu_cfg_t;

  localparam int CFG_W = $bits(fu_cfg_t);

endpackage

// File: rtl/fu_cfg_store.sv
module fu_cfg_store
  import fu_pkg::*;
#(
  parameter int PHASES = 16,
  parameter int PH_W   = 4
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            wr_en,
  input  logic [PH_W-1:0] wr_addr,
  input  logic [CFG_W-1:0] wr_data,
  input  logic [PH_W-1:0] rd_addr,
  output fu_cfg_t         rd_cfg
);

  logic [CFG_W-1:0] slots [PHASES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < PHASES; i++) slots[i] <= '0;
    end else if (wr_en && (int'(wr_addr) < PHASES)) begin
      slots[wr_addr] <= wr_data;
    end
  end

  always_comb begin
    rd_cfg = '0;
    if (int'(rd_addr) < PHASES) rd_cfg = fu_cfg_t'(slots[rd_addr]);
  end

  // R3: a written word is readable at its address after the edge
  a_r3_cfg_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && int'(wr_addr) < PHASES) |=> (slots[$past(wr_addr)] == $past(wr_data)));

endmodule

// File: rtl/fu_retime_reg.sv
module fu_retime_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic              pick_fb,
  input  logic [DATA_W-1:0] xbar_in,
  input  logic [DATA_W-1:0] fb_in,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst)       q <= '0;
    else if (load) q <= pick_fb ? fb_in : xbar_in;
  end

  // R4: without a load enable the operand is held
  a_r4_hold: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(q));

  // R8: feedback source chosen when selected
  a_r8_fb_source: assert property (@(posedge clk) disable iff (rst)
    (load && pick_fb) |=> (q == $past(fb_in)));

endmodule

// File: rtl/fu_alu.sv
module fu_alu
  import fu_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  fu_op_e            op,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic [DATA_W-1:0] y
);

  always_comb begin
    case (op)
      OP_ADD:  y = a + b;
      OP_SUB:  y = a - b;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_PASS: y = a;
      default: y = '0;
    endcase
  end

endmodule

// File: rtl/fu_retime_alu.sv
module fu_retime_alu
  import fu_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PHASES = 16,
  localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_we,
  input  logic [PH_W-1:0]   cfg_addr,
  input  logic [CFG_W-1:0]  cfg_data,
  input  logic [PH_W-1:0]   phase,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic [DATA_W-1:0] result
);

  localparam int N_OPND = 2;

  fu_cfg_t           cur;
  logic [DATA_W-1:0] fb_q;
  logic [DATA_W-1:0] alu_y;
  logic [DATA_W-1:0] xbar [N_OPND];
  logic [DATA_W-1:0] opq  [N_OPND];
  logic [N_OPND-1:0] load_v;
  logic [N_OPND-1:0] pick_v;

  fu_cfg_store #(.PHASES(PHASES), .PH_W(PH_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cfg_we),
    .wr_addr (cfg_addr),
    .wr_data (cfg_data),
    .rd_addr (phase),
    .rd_cfg  (cur)
  );

  assign xbar[0] = opnd_a;
  assign xbar[1] = opnd_b;
  assign load_v  = {cur.en_b, cur.en_a};
  assign pick_v  = {cur.sel_b, cur.sel_a};

  for (genvar i = 0; i < N_OPND; i++) begin : g_opnd
    fu_retime_reg #(.DATA_W(DATA_W)) u_rt (
      .clk     (clk),
      .rst     (rst),
      .load    (load_v[i]),
      .pick_fb (pick_v[i]),
      .xbar_in (xbar[i]),
      .fb_in   (fb_q),
      .q       (opq[i])
    );
  end

  fu_alu #(.DATA_W(DATA_W)) u_alu (
    .op (cur.op),
    .a  (opq[0]),
    .b  (opq[1]),
    .y  (alu_y)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      result <= '0;
      fb_q   <= '0;
    end else begin
      result <= alu_y;
      if (cur.fb_en) fb_q <= alu_y;
    end
  end

  // R9: reset clears the result and feedback registers
  a_r9_reset_clear: assert property (@(posedge clk)
    rst |=> (result == '0 && fb_q == '0));

  // R7: a capture makes feedback equal to the new result
  a_r7_fb_capture: assert property (@(posedge clk) disable iff (rst)
    cur.fb_en |=> (fb_q == result));

  // R7: no capture, feedback holds
  a_r7_fb_hold: assert property (@(posedge clk) disable iff (rst)
    !cur.fb_en |=> $stable(fb_q));

  // R1: pass returns the retimed A operand
  a_r1_pass: assert property (@(posedge clk) disable iff (rst)
    (cur.op == OP_PASS) |=> (result == $past(opq[0])));

  // R2: reserved opcodes give zero
  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (rst)
    (cur.op == OP_RSV6 || cur.op == OP_RSV7) |=> (result == '0));

endmodule

// File: tb/sim_fu_retime_alu.sv
module sim_fu_retime_alu;

  logic        clk = 1'b0;
  logic        rst;
  logic        cfg_we;
  logic [3:0]  cfg_addr;
  logic [7:0]  cfg_data;
  logic [3:0]  phase;
  logic [31:0] opnd_a;
  logic [31:0] opnd_b;
  logic [31:0] result;

  int n_chk  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  fu_retime_alu u0 (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_data(cfg_data), .phase(phase), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .result(result)
  );

  // {opcode, A, B, expected}
  localparam logic [98:0] VEC [12] = '{
    {3'b000, 32'h0000_0005, 32'h0000_0007, 32'h0000_000C},
    {3'b000, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000},
    {3'b000, 32'h8000_0000, 32'h8000_0000, 32'h0000_0000},
    {3'b001, 32'h0000_0003, 32'h0000_0005, 32'hFFFF_FFFE},
    {3'b001, 32'h0000_0100, 32'h0000_0001, 32'h0000_00FF},
    {3'b010, 32'hF0F0_F0F0, 32'h0FF0_0FF0, 32'h00F0_00F0},
    {3'b011, 32'hF0F0_F0F0, 32'h0F0F_0000, 32'hFFFF_F0F0},
    {3'b100, 32'hAAAA_AAAA, 32'hFFFF_0000, 32'h5555_AAAA},
    {3'b101, 32'h1234_5678, 32'hDEAD_BEEF, 32'h1234_5678},
    {3'b110, 32'h1111_1111, 32'h2222_2222, 32'h0000_0000},
    {3'b111, 32'h3333_3333, 32'h4444_4444, 32'h0000_0000},
    {3'b001, 32'h0000_0007, 32'h0000_0007, 32'h0000_0000}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: result=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input logic [3:0] ph, input logic [31:0] a, input logic [31:0] b);
    phase  = ph;
    opnd_a = a;
    opnd_b = b;
    @(negedge clk);
  endtask

  task automatic wcfg(input logic [3:0] addr, input logic [7:0] data);
    cfg_we   = 1'b1;
    cfg_addr = addr;
    cfg_data = data;
    @(negedge clk);
    cfg_we   = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst = 1'b1; cfg_we = 1'b0; cfg_addr = '0; cfg_data = '0;
    phase = '0; opnd_a = '0; opnd_b = '0;
    repeat (3) @(negedge clk);
    check("R9 reset state", result, 32'h0);
    rst = 1'b0;

    // R1 R2 R6: operation table, phase 0 loads both operands
    for (int i = 0; i < 12; i++) begin
      wcfg(4'd0, {5'b11000, VEC[i][98:96]});
      tick(4'd0, VEC[i][95:64], VEC[i][63:32]);
      tick(4'd0, VEC[i][95:64], VEC[i][63:32]);
      check($sformatf("R1/R2 vector %0d", i), result, VEC[i][31:0]);
    end

    // R4: phase 1 has no enables, operands held across cycles
    wcfg(4'd1, 8'b00000_000);
    wcfg(4'd0, 8'b11000_000);
    tick(4'd0, 32'd10, 32'd20);
    tick(4'd1, 32'd999, 32'd999);
    tick(4'd1, 32'd999, 32'd999);
    tick(4'd1, 32'd999, 32'd999);
    check("R4 hold across phases", result, 32'd30);

    // R5: capture A, then B, combine later with subtract
    wcfg(4'd2, 8'b10000_101);
    wcfg(4'd3, 8'b01000_101);
    wcfg(4'd4, 8'b00000_001);
    tick(4'd2, 32'd100, 32'hBAD0_BAD0);
    tick(4'd3, 32'hBAD1_BAD1, 32'd40);
    tick(4'd4, 32'hBAD2_BAD2, 32'hBAD3_BAD3);
    check("R5 reordered operands", result, 32'd60);

    // R7 R8: chain through the feedback register
    wcfg(4'd5, 8'b11001_000);
    wcfg(4'd6, 8'b11100_000);
    wcfg(4'd7, 8'b00000_000);
    tick(4'd5, 32'd3, 32'd4);
    tick(4'd5, 32'd3, 32'd4);
    check("R6 result after two edges", result, 32'd7);
    tick(4'd6, 32'hFFFF_0000, 32'd10);
    tick(4'd7, 32'd0, 32'd0);
    check("R8 A from feedback", result, 32'd17);
    tick(4'd6, 32'hFFFF_0000, 32'd1);
    tick(4'd7, 32'd0, 32'd0);
    check("R7 feedback held without capture", result, 32'd8);
    wcfg(4'd8, 8'b11010_000);
    tick(4'd8, 32'd50, 32'hFFFF_FFFF);
    tick(4'd7, 32'd0, 32'd0);
    check("R8 B from feedback", result, 32'd57);

    // R10: highest phase index has its own entry
    wcfg(4'd15, 8'b11000_011);
    tick(4'd15, 32'h0000_F000, 32'h0000_000F);
    tick(4'd15, 32'h0000_F000, 32'h0000_000F);
    check("R10 phase 15 entry", result, 32'h0000_F00F);

    // R3: writing phase 15 left phase 0 untouched (add)
    tick(4'd0, 32'd9, 32'd4);
    tick(4'd0, 32'd9, 32'd4);
    check("R3 other entry unchanged", result, 32'd13);

    // R9: reset mid-run clears operands and configuration
    rst = 1'b1;
    tick(4'd0, 32'd9, 32'd4);
    rst = 1'b0;
    check("R9 reset clears result", result, 32'h0);
    tick(4'd0, 32'd9, 32'd4);
    tick(4'd0, 32'd9, 32'd4);
    check("R9 cleared config and operands", result, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule